// File: doc/BRIEF.md
# Chainable Eight-Channel Serial Converter Register Controller

This block is the digital front end of an eight-channel, 10-bit voltage-output converter. A host drives a three-wire serial port made of a clock, a data line and an active-low select/load strobe. While the strobe is low, 16-bit command words shift in on rising clock edges. When the strobe rises, the most recent 16 bits are decoded. The decoded command loads one channel register, loads all eight channel registers, puts the part to sleep, or leaves every register as it is.

The bit that leaves the far end of the shift register is retimed onto a serial output on the falling clock edge. Several devices can therefore be chained: each device's serial output feeds the data input of the next. One strobe-low period then carries one word per device, and every device in the chain acts on the same rising strobe edge. An active-low clear input works asynchronously. It zeroes the shift register, the serial output and all channel registers, and returns the sleep flag to awake.

Top module: `dac8_serial_ctrl`

## Requirements
- R1: On a rising `ser_clk` edge with `sel_load_n` low, the shift register moves one place toward its MSB and takes `ser_in` into bit 0, so a word is sent MSB first. With `sel_load_n` high, `ser_in` and `ser_clk` leave the shift register unchanged.
- R2: A rising edge of `sel_load_n` decodes the current 16-bit shift contents. The address is in bits 15:12 and the data code in bits 11:2. Bits 1:0 have no effect.
- R3: Address values 1 to 8 load the data code into channel 0 to 7 (address minus one), which is `dac_codes[10*ch +: 10]`. The other channels keep their values.
- R4: Address 15 loads the same data code into all eight channels.
- R5: Address values 0, 9, 10, 11, 12 and 13 leave every channel register unchanged.
- R6: Address 14 sets `asleep` to 1 and leaves every channel register unchanged.
- R7: A load with any address other than 14 clears `asleep`. This includes the values listed in R5.
- R8: `ser_out` changes on the falling `ser_clk` edge. After the falling edge that follows the n-th shifting rising edge, it shows the bit taken in at the (n-15)-th shifting edge, or 0 when fewer than 16 bits have been taken in since clear.
- R9: While `wipe_n` is low, without waiting for a clock, the shift register, `ser_out`, every channel register and `asleep` are 0. A rising `sel_load_n` in that time loads nothing.
- R10: When more than 16 bits are sent in one strobe-low period, only the last 16 are decoded. The earlier bits leave on `ser_out` in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ser_clk | input | 1 | Serial shift clock |
| ser_in | input | 1 | Serial data input, sampled on rising `ser_clk` |
| sel_load_n | input | 1 | Active-low select; its rising edge applies the command |
| wipe_n | input | 1 | Asynchronous active-low clear |
| ser_out | output | 1 | Chained serial output, updated on falling `ser_clk` |
| asleep | output | 1 | Sleep flag, 1 after a sleep command |
| dac_codes | output | 80 | Eight 10-bit channel codes; channel k in bits 10k+9:10k |

## Verification
Single-channel loads with distinct values on every channel separate correct address-to-channel mapping from swapped or shifted slots. A broadcast load followed by a single-channel load shows that the per-channel and all-channel paths are independent. Each no-change code and the sleep code is sent over known register contents, and is followed by wake-up traffic, to separate "ignored" from "partly decoded". A two-word frame, toggling of the data line while the strobe is high, and a clear in the middle of a frame exercise the chain output, the rule that only the last word is decoded, the shift gating and the priority of clear. A behavioural model built on a bit history is compared with all outputs on every clock.

// File: rtl/dacctl_pkg.sv
package dacctl_pkg;
   typedef enum logic [1:0] {
      CMD_HOLD  = 2'd0,
      CMD_ONE   = 2'd1,
      CMD_ALL   = 2'd2,
      CMD_SLEEP = 2'd3
   } cmd_e;
endpackage

// File: rtl/dacctl_shifter.sv
module dacctl_shifter #(
   parameter int WORD_W     = 16,
   parameter bit SDO_RETIME = 1'b1
) (
   input  logic              sck,
   input  logic              clr_n,
   input  logic              cs_n,
   input  logic              sdi,
   output logic [WORD_W-1:0] word_o,
   output logic              sdo
);
   logic [WORD_W-1:0] sh_q;

   always_ff @(posedge sck or negedge clr_n) begin
      if (!clr_n)     sh_q <= '0;
      else if (!cs_n) sh_q <= {sh_q[WORD_W-2:0], sdi};
   end

   assign word_o = sh_q;

   generate
      if (SDO_RETIME) begin : g_fall
         logic sdo_q;
         always_ff @(negedge sck or negedge clr_n) begin
            if (!clr_n) sdo_q <= 1'b0;
            else        sdo_q <= sh_q[WORD_W-1];
         end
         assign sdo = sdo_q;

         // R8: output follows the shift MSB one falling edge later
         a_r8_sdo_fall: assert property (@(negedge sck) disable iff (!clr_n)
            sdo == $past(sh_q[WORD_W-1]));
      end else begin : g_direct
         assign sdo = sh_q[WORD_W-1];
      end
   endgenerate

   // R1: bit 0 takes the serial input while selected
   a_r1_shift_in: assert property (@(posedge sck) disable iff (!clr_n)
      !cs_n |=> sh_q[0] == $past(sdi));
   // R1: deselected clocks leave the shift contents alone
   a_r1_hold: assert property (@(posedge sck) disable iff (!clr_n)
      cs_n |=> $stable(sh_q));
   // R9: clear holds the shift path at zero
   a_r9_clear_shift: assert property (@(posedge sck)
      !clr_n |-> (sh_q == '0 && sdo == 1'b0));
endmodule

// File: rtl/dacctl_decode.sv
module dacctl_decode
   import dacctl_pkg::*;
#(
   parameter int WORD_W   = 16,
   parameter int ADDR_W   = 4,
   parameter int CODE_W   = 10,
   parameter int CH_COUNT = 8,
   parameter int SEL_W    = 3
) (
   input  logic [WORD_W-1:0] word_i,
   output cmd_e              cmd_o,
   output logic [SEL_W-1:0]  sel_o,
   output logic [CODE_W-1:0] code_o
);
   localparam logic [ADDR_W-1:0] ALL_ADDR   = '1;
   localparam logic [ADDR_W-1:0] SLEEP_ADDR = ALL_ADDR - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] LAST_CH    = ADDR_W'(CH_COUNT);

   logic [ADDR_W-1:0] addr;
   logic [ADDR_W-1:0] idx;

   assign addr   = word_i[WORD_W-1 -: ADDR_W];
   assign code_o = word_i[WORD_W-ADDR_W-1 -: CODE_W];
   assign idx    = addr - ADDR_W'(1);
   assign sel_o  = idx[SEL_W-1:0];

   always_comb begin
      if (addr == ALL_ADDR)                           cmd_o = CMD_ALL;
      else if (addr == SLEEP_ADDR)                    cmd_o = CMD_SLEEP;
      else if (addr != '0 && addr <= LAST_CH)         cmd_o = CMD_ONE;
      else                                            cmd_o = CMD_HOLD;
   end
endmodule

// File: rtl/dacctl_bank.sv
module dacctl_bank
   import dacctl_pkg::*;
#(
   parameter int CH_COUNT = 8,
   parameter int CODE_W   = 10,
   parameter int SEL_W    = 3
) (
   input  logic                       ld,
   input  logic                       clr_n,
   input  cmd_e                       cmd,
   input  logic [SEL_W-1:0]           sel,
   input  logic [CODE_W-1:0]          code,
   output logic [CH_COUNT*CODE_W-1:0] codes_o,
   output logic                       sleep_o
);
   logic [CODE_W-1:0] reg_q [CH_COUNT];

   generate
      for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
         always_ff @(posedge ld or negedge clr_n) begin
            if (!clr_n)
               reg_q[g] <= '0;
            else if (cmd == CMD_ALL || (cmd == CMD_ONE && sel == SEL_W'(g)))
               reg_q[g] <= code;
         end
         assign codes_o[g*CODE_W +: CODE_W] = reg_q[g];

         // R4: broadcast reaches every channel
         a_r4_all: assert property (@(posedge ld) disable iff (!clr_n)
            $past(cmd) == CMD_ALL |-> reg_q[g] == $past(code));
      end
   endgenerate

   always_ff @(posedge ld or negedge clr_n) begin
      if (!clr_n) sleep_o <= 1'b0;
      else        sleep_o <= (cmd == CMD_SLEEP);
   end

   // R3: the addressed channel takes the code
   a_r3_one: assert property (@(posedge ld) disable iff (!clr_n)
      $past(cmd) == CMD_ONE |-> reg_q[$past(sel)] == $past(code));
   // R5: hold commands leave all channels unchanged
   a_r5_hold: assert property (@(posedge ld) disable iff (!clr_n)
      $past(cmd) == CMD_HOLD |-> codes_o == $past(codes_o));
   // R6: sleep raises the flag and keeps the channels
   a_r6_sleep: assert property (@(posedge ld) disable iff (!clr_n)
      $past(cmd) == CMD_SLEEP |-> (sleep_o && codes_o == $past(codes_o)));
   // R7: any other command wakes
   a_r7_wake: assert property (@(posedge ld) disable iff (!clr_n)
      $past(cmd) != CMD_SLEEP |-> !sleep_o);
   // R9: a strobe during clear loads nothing
   a_r9_clear_bank: assert property (@(posedge ld)
      !clr_n |-> (codes_o == '0 && !sleep_o));
endmodule

// File: rtl/dac8_serial_ctrl.sv
module dac8_serial_ctrl
   import dacctl_pkg::*;
#(
   parameter int CH_COUNT   = 8,
   parameter int CODE_W     = 10,
   parameter int ADDR_W     = 4,
   parameter int WORD_W     = 16,
   parameter bit SDO_RETIME = 1'b1
) (
   input  logic                       ser_clk,
   input  logic                       ser_in,
   input  logic                       sel_load_n,
   input  logic                       wipe_n,
   output logic                       ser_out,
   output logic                       asleep,
   output logic [CH_COUNT*CODE_W-1:0] dac_codes
);
   localparam int SEL_W = (CH_COUNT > 1) ? $clog2(CH_COUNT) : 1;

   generate
      if (WORD_W < ADDR_W + CODE_W) begin : g_bad_word
         $error("word too narrow for address and code");
      end
      if (CH_COUNT + 2 >= (1 << ADDR_W)) begin : g_bad_addr
         $error("address space cannot hold channels plus sleep and broadcast");
      end
      if (SEL_W > ADDR_W) begin : g_bad_sel
         $error("channel select wider than address");
      end
   endgenerate

   logic [WORD_W-1:0] word;
   cmd_e              cmd;
   logic [SEL_W-1:0]  sel;
   logic [CODE_W-1:0] code;

   dacctl_shifter #(.WORD_W(WORD_W), .SDO_RETIME(SDO_RETIME)) u_shift (
      .sck(ser_clk), .clr_n(wipe_n), .cs_n(sel_load_n), .sdi(ser_in),
      .word_o(word), .sdo(ser_out)
   );

   dacctl_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .CODE_W(CODE_W),
                   .CH_COUNT(CH_COUNT), .SEL_W(SEL_W)) u_dec (
      .word_i(word), .cmd_o(cmd), .sel_o(sel), .code_o(code)
   );

   dacctl_bank #(.CH_COUNT(CH_COUNT), .CODE_W(CODE_W), .SEL_W(SEL_W)) u_bank (
      .ld(sel_load_n), .clr_n(wipe_n), .cmd(cmd), .sel(sel), .code(code),
      .codes_o(dac_codes), .sleep_o(asleep)
   );
endmodule

// File: tb/dac8_serial_ctrl_bench.sv
module dac8_serial_ctrl_bench;
   timeunit 1ns; timeprecision 100ps;

   logic        ser_clk = 1'b0;
   logic        ser_in = 1'b0;
   logic        sel_load_n = 1'b1;
   logic        wipe_n = 1'b0;
   logic        ser_out;
   logic        asleep;
   logic [79:0] dac_codes;

   dac8_serial_ctrl u_dac8_serial_ctrl (
      .ser_clk(ser_clk), .ser_in(ser_in), .sel_load_n(sel_load_n),
      .wipe_n(wipe_n), .ser_out(ser_out), .asleep(asleep), .dac_codes(dac_codes)
   );

   always #2 ser_clk = ~ser_clk;   // 250 MHz

   int  errors = 0;
   int  checks = 0;
   bit  done = 0;
   bit  started = 0;
   bit  hist[$];
   int  m_code[8];
   bit  m_sleep = 0;

   function automatic int chv(int ch);
      return int'(dac_codes[ch*10 +: 10]);
   endfunction

   function automatic bit m_sdo();
      if (hist.size() < 16) return 1'b0;
      return hist[hist.size()-16];
   endfunction

   function automatic logic [15:0] m_word();
      logic [15:0] w;
      for (int i = 0; i < 16; i++)
         w[i] = (hist.size() > i) ? hist[hist.size()-1-i] : 1'b0;
      return w;
   endfunction

   task automatic check(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_apply();
      logic [15:0] w;
      int a, d;
      w = m_word();
      a = int'(w[15:12]);
      d = int'(w[11:2]);
      if (a >= 1 && a <= 8) m_code[a-1] = d;
      else if (a == 15) for (int c = 0; c < 8; c++) m_code[c] = d;
      m_sleep = (a == 14);
   endtask

   // model shift history
   always @(posedge ser_clk) begin
      if (wipe_n && !sel_load_n) begin
         hist.push_back(ser_in);
         if (hist.size() > 64) void'(hist.pop_front());
      end
   end

   // per-clock comparison against the model
   always @(negedge ser_clk) begin
      if (started && wipe_n) begin
         #0.5;
         for (int c = 0; c < 8; c++) check("R3 R4 R5 channel code", chv(c), m_code[c]);
         check("R6 R7 asleep", int'(asleep), int'(m_sleep));
         check("R8 ser_out", int'(ser_out), int'(m_sdo()));
      end
   end

   task automatic bit_out(bit b);
      @(negedge ser_clk); #1;
      sel_load_n = 1'b0;
      ser_in = b;
   endtask

   task automatic end_frame();
      @(negedge ser_clk); #1;
      sel_load_n = 1'b1;
      if (wipe_n) model_apply();
   endtask

   task automatic shift_word(int a, int d, int dc);
      logic [15:0] w;
      w = {a[3:0], d[9:0], dc[1:0]};
      for (int i = 15; i >= 0; i--) bit_out(w[i]);
   endtask

   task automatic send_word(int a, int d, int dc = 0);
      shift_word(a, d, dc);
      end_frame();
      #1;
   endtask

   task automatic clear_on();
      wipe_n = 1'b0;
      hist.delete();
      for (int c = 0; c < 8; c++) m_code[c] = 0;
      m_sleep = 0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired at %0t", $time);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] w1;
      logic [15:0] seen;
      for (int c = 0; c < 8; c++) m_code[c] = 0;
      #10;
      // R9 reset state
      check("R9 reset asleep", int'(asleep), 0);
      check("R9 reset ser_out", int'(ser_out), 0);
      check("R9 reset codes", int'(dac_codes == '0), 1);
      @(negedge ser_clk); #1; wipe_n = 1'b1; started = 1;

      // R3 each channel
      for (int c = 0; c < 8; c++) send_word(c + 1, 100 * c + 37);
      check("R3 channel 5", chv(5), 537);
      check("R3 channel 0", chv(0), 37);
      check("R3 channel 7", chv(7), 737);

      // R4 broadcast then single
      send_word(15, 1023);
      check("R4 channel 3 broadcast", chv(3), 1023);
      send_word(2, 5);
      check("R3 channel 1 after broadcast", chv(1), 5);
      check("R3 channel 2 untouched", chv(2), 1023);

      // R5 no-change codes
      send_word(0, 11); send_word(9, 12); send_word(10, 13);
      send_word(11, 14); send_word(12, 15); send_word(13, 16);
      check("R5 channel 0 held", chv(0), 1023);
      check("R5 channel 1 held", chv(1), 5);

      // R6 sleep, R7 wake by no-change
      send_word(14, 77);
      check("R6 asleep set", int'(asleep), 1);
      check("R6 channel 1 held", chv(1), 5);
      send_word(0, 9);
      check("R7 woken by no-change", int'(asleep), 0);
      send_word(14, 0);
      send_word(8, 300);
      check("R7 woken by load", int'(asleep), 0);
      check("R3 channel 7 loaded", chv(7), 300);

      // R1 data ignored while deselected, then zero-clock strobe
      for (int i = 0; i < 20; i++) begin
         @(negedge ser_clk); #1; ser_in = i[0];
      end
      @(negedge ser_clk); #1; sel_load_n = 1'b0; #0.5; sel_load_n = 1'b1; model_apply();
      #2;
      check("R1 shift held ser_out", int'(ser_out), 1);
      check("R1 channel 7 kept", chv(7), 300);

      // R10 two-word frame, R8 chain output
      w1 = {4'd1, 10'd111, 2'b00};
      shift_word(1, 111, 0);
      for (int i = 15; i >= 0; i--) begin
         logic [15:0] w2;
         w2 = {4'd6, 10'd222, 2'b01};
         bit_out(w2[i]);
         seen[i] = ser_out;
      end
      end_frame(); #1;
      check("R8 chain word out", int'(seen), int'(w1));
      check("R10 last word applied", chv(5), 222);
      check("R10 first word not applied", chv(0), 1023);

      // R9 clear mid-frame with sleep set
      send_word(14, 0);
      for (int i = 0; i < 8; i++) bit_out(1'b1);
      clear_on(); #0.5;
      check("R9 async codes", int'(dac_codes == '0), 1);
      check("R9 async asleep", int'(asleep), 0);
      check("R9 async ser_out", int'(ser_out), 0);
      for (int i = 0; i < 8; i++) begin
         @(negedge ser_clk); #1; ser_in = 1'b1;
      end
      @(negedge ser_clk); #1; sel_load_n = 1'b1;
      #2;
      check("R9 strobe during clear", int'(dac_codes == '0), 1);
      @(negedge ser_clk); #1; wipe_n = 1'b1;
      #2;
      check("R9 after release", int'(dac_codes == '0), 1);

      // R2 don't-care bits
      send_word(7, 512, 3);
      check("R2 channel 6 with dc bits", chv(6), 512);
      check("R2 channel 5 zero", chv(5), 0);

      repeat (4) @(negedge ser_clk);
      #1;
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule